// File: doc/BRIEF.md
# Six-Pin GPIO Controller with Shared Level Interrupt

This block drives and samples a small group of general-purpose pins through a 32-bit register port. Three registers make up its map. A control register gives each pin a two-bit direction code and also holds the interrupt settings. An output register sets the level driven on each pin. A read-only input register shows the synchronised pin levels. Output enables for the pads come straight from the direction codes. A pin whose code is anything other than all ones is released to high impedance.

Software can pick any one pin as the interrupt source, with an active-high or active-low condition. The block then holds a single level-sensitive interrupt line to the host for as long as that condition lasts. Pad inputs pass through a two-flop synchroniser before they reach the input register or the interrupt compare. When the interrupt is enabled on a pin, a write to the control register forces that pin's direction code to input. Reads of the input register go through a fixed mask, so pin 4 always reads as zero there.

Top module: `gpio_sel_irq`

## Requirements
- R1: After reset, the control and output registers read 0, every pad enable is low (all pins are inputs) and the interrupt line is low.
- R2: Pin n's direction code sits at control bits [2n+1:2n]. A code of 2'b11 drives pad_oe[n] high. Codes 2'b00, 2'b01 and 2'b10 keep it low. pad_out[n] always equals output register bit n.
- R3: The control register (offset 0x0) stores bits [17:0] and reads them back. Bits [31:18] read as 0. The interrupt pin index sits at [14:12], the enable bit at 15 and the level code at [17:16].
- R4: The output register (offset 0x4) stores bits [5:0], and bit n drives pin n. Bits [31:6] read as 0. A write replaces all six bits, so a read-modify-write of one bit leaves the others unchanged.
- R5: The input register (offset 0x8) reads the pin levels after a two-flop synchroniser, with mask 0x2F applied. Bit 4 and bits [31:6] always read 0. A new pad level is visible after two rising clock edges. Writes to this offset are ignored.
- R6: If a control write sets enable bit 15 and an index in [14:12] below 6, the direction code of that pin is stored as 2'b00. All other fields are stored as written. With bit 15 clear, no code is forced.
- R7: The interrupt output is registered. It is high while the enable bit is 1, the index is 0 to 5, and either the level code is 2'b11 and the synchronised pin is 1, or the code is 2'b01 and the pin is 0. A pad change shows on the interrupt after three rising edges. Pin 4 can be an interrupt source even though its read-back is masked.
- R8: The interrupt stays low if the enable bit is 0, if the index is 6 or 7, or if the level code is 2'b00 or 2'b10.
- R9: Offsets other than 0x0, 0x4 and 0x8 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 8 | Byte offset of the register accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| pad_in_i | input | 6 | Levels seen at the pins |
| pad_out_o | output | 6 | Levels driven onto the pins |
| pad_oe_o | output | 6 | Pad output enables, high to drive |
| irq_o | output | 1 | Shared level interrupt to the host |

## Verification
The bench builds the block with its default parameters: six pins, a 32-bit port, an 8-bit offset, two synchroniser stages and read mask 0x2F. With six pins, the three-bit index field has two values that name no pin, so the out-of-range indexes 6 and 7 can be tested. The mask hides pin 4, so a masked pin can be shown to read zero while still raising the interrupt. The two-stage synchroniser gives exact edge counts for both the input read-back and the interrupt.

// File: rtl/gpio_sel_irq_pkg.sv
package gpio_sel_irq_pkg;

    // Direction codes of a pin field
    localparam logic [1:0] DIR_OUT = 2'b11;
    localparam logic [1:0] DIR_IN  = 2'b00;

    // Level codes of the interrupt select field
    typedef enum logic [1:0] {
        LVL_OFF_A = 2'b00,
        LVL_LOW   = 2'b01,
        LVL_OFF_B = 2'b10,
        LVL_HIGH  = 2'b11
    } lvl_code_e;

    // Register byte offsets
    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_DOUT = 4;
    localparam int unsigned OFS_DIN  = 8;

endpackage

// File: rtl/gpio_sel_irq_sync.sv
module gpio_sel_irq_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
            // R5: each stage takes the previous stage one edge later
            assert_stage_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                chain_q[g] == $past(chain_q[g-1]));
        end
    endgenerate

endmodule

// File: rtl/gpio_sel_irq_regs.sv
module gpio_sel_irq_regs
    import gpio_sel_irq_pkg::*;
#(
    parameter int unsigned          NUM_PINS = 6,
    parameter int unsigned          DATA_W   = 32,
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [NUM_PINS-1:0]  RD_MASK  = 6'h2F,
    localparam int unsigned         SEL_W    = $clog2(NUM_PINS),
    localparam int unsigned         SEL_LSB  = 2 * NUM_PINS,
    localparam int unsigned         EN_BIT   = SEL_LSB + SEL_W,
    localparam int unsigned         LVL_LSB  = EN_BIT + 1,
    localparam int unsigned         CTRL_W   = LVL_LSB + 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_PINS-1:0] din_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [NUM_PINS-1:0] dout_o
);

    typedef struct packed {
        logic [CTRL_W-1:0]   ctrl;
        logic [NUM_PINS-1:0] dout;
    } regs_t;

    regs_t st_d, st_q;
    logic [CTRL_W-1:0] ctrl_new;
    logic [SEL_W-1:0]  new_sel;
    logic              unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:CTRL_W];
    assign new_sel   = wdata_i[SEL_LSB +: SEL_W];

    always_comb begin
        st_d     = st_q;
        ctrl_new = wdata_i[CTRL_W-1:0];
        if (wdata_i[EN_BIT]) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (new_sel == SEL_W'(p)) ctrl_new[2*p +: 2] = DIR_IN;
            end
        end
        if (wr_i) begin
            if (addr_i == ADDR_W'(OFS_CTRL))      st_d.ctrl = ctrl_new;
            else if (addr_i == ADDR_W'(OFS_DOUT)) st_d.dout = wdata_i[NUM_PINS-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_CTRL))      rdata_o = DATA_W'(st_q.ctrl);
        else if (addr_i == ADDR_W'(OFS_DOUT)) rdata_o = DATA_W'(st_q.dout);
        else if (addr_i == ADDR_W'(OFS_DIN))  rdata_o = DATA_W'(din_i & RD_MASK);
    end

    assign ctrl_o = st_q.ctrl;
    assign dout_o = st_q.dout;

    // R6: enabling the interrupt on a valid pin leaves that pin an input
    assert_sel_forces_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADDR_W'(OFS_CTRL) && wdata_i[EN_BIT] && new_sel == '0)
        |=> (st_q.ctrl[1:0] == DIR_IN));

    // R4: a write to the output register lands on the next edge
    assert_dout_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADDR_W'(OFS_DOUT))
        |=> (st_q.dout == $past(wdata_i[NUM_PINS-1:0])));

    // R4, R9: without a write the output register holds
    assert_dout_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i) |=> $stable(st_q.dout));

    // R9: writes to unmapped offsets leave the control register unchanged
    assert_ctrl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i != ADDR_W'(OFS_CTRL)) |=> $stable(st_q.ctrl));

endmodule

// File: rtl/gpio_sel_irq_irq.sv
module gpio_sel_irq_irq
    import gpio_sel_irq_pkg::*;
#(
    parameter int unsigned  NUM_PINS = 6,
    localparam int unsigned SEL_W    = $clog2(NUM_PINS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_lvl_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                en_i,
    input  logic [1:0]          lvl_i,
    output logic                irq_o
);

    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    picked;
    logic    sel_ok;

    always_comb begin
        picked = 1'b0;
        sel_ok = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sel_i == SEL_W'(p)) begin
                picked = pin_lvl_i[p];
                sel_ok = 1'b1;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (en_i && sel_ok) begin
            if (lvl_i == LVL_HIGH)     st_d.irq = picked;
            else if (lvl_i == LVL_LOW) st_d.irq = ~picked;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R8: a disabled interrupt stays low
    assert_irq_off_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i) |=> !irq_o);

    // R8: an index naming no pin stays low
    assert_irq_off_badsel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sel_i) >= NUM_PINS) |=> !irq_o);

    // R8: the unused level codes stay low
    assert_irq_off_lvl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_i == LVL_OFF_A || lvl_i == LVL_OFF_B) |=> !irq_o);

    // R7: pin 0 high with level code high raises the line
    assert_irq_high_pin0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && sel_i == '0 && lvl_i == LVL_HIGH && pin_lvl_i[0]) |=> irq_o);

endmodule

// File: rtl/gpio_sel_irq.sv
module gpio_sel_irq
    import gpio_sel_irq_pkg::*;
#(
    parameter int unsigned         NUM_PINS    = 6,
    parameter int unsigned         DATA_W      = 32,
    parameter int unsigned         ADDR_W      = 8,
    parameter int unsigned         SYNC_STAGES = 2,
    parameter logic [NUM_PINS-1:0] RD_MASK     = 6'h2F
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic                irq_o
);

    localparam int unsigned SEL_W   = $clog2(NUM_PINS);
    localparam int unsigned SEL_LSB = 2 * NUM_PINS;
    localparam int unsigned EN_BIT  = SEL_LSB + SEL_W;
    localparam int unsigned LVL_LSB = EN_BIT + 1;
    localparam int unsigned CTRL_W  = LVL_LSB + 2;

    logic [NUM_PINS-1:0] pin_sync;
    logic [CTRL_W-1:0]   ctrl;
    logic [NUM_PINS-1:0] dout;

    gpio_sel_irq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pad_in_i),
        .sync_o  (pin_sync)
    );

    gpio_sel_irq_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RD_MASK  (RD_MASK)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .din_i   (pin_sync),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl),
        .dout_o  (dout)
    );

    gpio_sel_irq_irq #(
        .NUM_PINS (NUM_PINS)
    ) irq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_lvl_i (pin_sync),
        .sel_i     (ctrl[SEL_LSB +: SEL_W]),
        .en_i      (ctrl[EN_BIT]),
        .lvl_i     (ctrl[LVL_LSB +: 2]),
        .irq_o     (irq_o)
    );

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
            assign pad_oe_o[n] = (ctrl[2*n +: 2] == DIR_OUT);
        end
    endgenerate

    assign pad_out_o = dout;

    // R2: a pin driven while its field is not the output code is an error
    assert_oe_needs_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl[1:0] != DIR_OUT) |-> !pad_oe_o[0]);

endmodule

// File: tb/gpio_sel_irq_tb_top.sv
module gpio_sel_irq_tb_top;

    logic        clk;
    logic        rst_n;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [5:0]  pad_in;
    logic [5:0]  pad_out;
    logic [5:0]  pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    gpio_sel_irq dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pad_in_i    (pad_in),
        .pad_out_o   (pad_out),
        .pad_oe_o    (pad_oe),
        .irq_o       (irq)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_pads(input logic [5:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(8'h0, v); chk("R1 ctrl", v, 32'h0);
        rd_reg(8'h4, v); chk("R1 dout", v, 32'h0);
        chk("R1 oe", {26'h0, pad_oe}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_rw();
        logic [31:0] v;
        wr_reg(8'h0, 32'hFFFF_FFFF);
        rd_reg(8'h0, v); chk("R3 ctrl readback", v, 32'h0003_FFFF);
        chk("R2 all out", {26'h0, pad_oe}, 32'h3F);
        wr_reg(8'h0, 32'h0);
    endtask

    task automatic t_dir_codes();
        wr_reg(8'h0, 32'h0000_0F27);
        chk("R2 mixed codes", {26'h0, pad_oe}, 32'h31);
        wr_reg(8'h0, 32'h0);
        chk("R2 all in", {26'h0, pad_oe}, 32'h0);
    endtask

    task automatic t_dout();
        logic [31:0] v;
        wr_reg(8'h4, 32'h2A);
        rd_reg(8'h4, v); chk("R4 dout", v, 32'h2A);
        chk("R2 pad_out", {26'h0, pad_out}, 32'h2A);
        wr_reg(8'h4, 32'hFFFF_FFC5);
        rd_reg(8'h4, v); chk("R4 upper zero", v, 32'h05);
        rd_reg(8'h4, v); wr_reg(8'h4, v | 32'h8);
        rd_reg(8'h4, v); chk("R4 rmw set bit3", v, 32'h0D);
        wr_reg(8'h4, v & ~32'h1);
        rd_reg(8'h4, v); chk("R4 rmw clear bit0", v, 32'h0C);
        chk("R2 pad_out rmw", {26'h0, pad_out}, 32'h0C);
    endtask

    task automatic t_din();
        logic [31:0] v;
        set_pads(6'h3F);
        rd_reg(8'h8, v); chk("R5 din mask", v, 32'h2F);
        set_pads(6'h10);
        rd_reg(8'h8, v); chk("R5 pin4 hidden", v, 32'h0);
        set_pads(6'h15);
        rd_reg(8'h8, v); chk("R5 pattern", v, 32'h05);
        wr_reg(8'h8, 32'hFFFF_FFFF);
        rd_reg(8'h8, v); chk("R5 write ignored", v, 32'h05);
        // latency: new level after two edges
        @(negedge clk);
        addr = 8'h8; pad_in = 6'h2A;
        @(negedge clk); chk("R5 one edge old", rdata, 32'h05);
        @(negedge clk); chk("R5 two edges new", rdata, 32'h2A);
        set_pads(6'h00);
    endtask

    task automatic t_force();
        logic [31:0] v;
        wr_reg(8'h0, 32'h0003_AFFF);
        rd_reg(8'h0, v); chk("R6 forced field", v, 32'h0003_AFCF);
        chk("R6 pin2 released", {26'h0, pad_oe}, 32'h3B);
        wr_reg(8'h0, 32'h0003_2FFF);
        rd_reg(8'h0, v); chk("R6 no force when off", v, 32'h0003_2FFF);
        wr_reg(8'h0, 32'h0);
    endtask

    task automatic t_irq_high();
        wr_reg(8'h0, 32'h0003_9000);
        set_pads(6'h00);
        chk("R7 high idle", {31'h0, irq}, 32'h0);
        @(negedge clk);
        pad_in = 6'h02;
        @(negedge clk); @(negedge clk);
        chk("R7 two edges still low", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 three edges high", {31'h0, irq}, 32'h1);
        set_pads(6'h3D);
        chk("R7 drops with pin", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_irq_low();
        wr_reg(8'h0, 32'h0001_C000);
        set_pads(6'h10);
        chk("R7 low idle", {31'h0, irq}, 32'h0);
        set_pads(6'h00);
        chk("R7 low pin4", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_irq_off();
        wr_reg(8'h0, 32'h0000_8000);
        set_pads(6'h3F);
        chk("R8 code 00 pin high", {31'h0, irq}, 32'h0);
        set_pads(6'h00);
        chk("R8 code 00 pin low", {31'h0, irq}, 32'h0);
        wr_reg(8'h0, 32'h0002_8000);
        repeat (2) @(negedge clk);
        chk("R8 code 10", {31'h0, irq}, 32'h0);
        wr_reg(8'h0, 32'h0003_E000);
        set_pads(6'h3F);
        chk("R8 sel 6", {31'h0, irq}, 32'h0);
        wr_reg(8'h0, 32'h0001_F000);
        set_pads(6'h00);
        chk("R8 sel 7", {31'h0, irq}, 32'h0);
        wr_reg(8'h0, 32'h0003_1000);
        set_pads(6'h02);
        chk("R8 disabled", {31'h0, irq}, 32'h0);
        wr_reg(8'h0, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr_reg(8'h0, 32'h0000_0123);
        wr_reg(8'h4, 32'h11);
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        rd_reg(8'h0C, v); chk("R9 unmapped read", v, 32'h0);
        rd_reg(8'h0, v);  chk("R9 ctrl kept", v, 32'h0000_0123);
        rd_reg(8'h4, v);  chk("R9 dout kept", v, 32'h11);
    endtask

    initial begin
        rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_rw();
        t_dir_codes();
        t_dout();
        t_din();
        t_force();
        t_irq_high();
        t_irq_low();
        t_irq_off();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule